// File: doc/BRIEF.md
# Coprocessor State Save/Restore Sequencer

This block moves the architectural state of a floating-point coprocessor between the unit and memory. It uses a plain 32-bit request/acknowledge bus. A command names one of four operations and a byte base address.

There are two write operations and two read operations:
- Environment store writes seven words holding the control, status and tag words and the last-instruction pointers.
- Full save writes those seven words, then the eight 80-bit stack registers, for 27 words in total. When the last word is written, the block pulses the initialize output.
- Environment load reads the seven-word image back.
- Full restore reads the 27-word image back.

Each command carries a wait flag. With the flag set, the block does not start the transfer while the coprocessor busy flag is high. With the flag clear, the transfer starts at once.

Commands arrive on a valid/ready handshake. `cmd_ready` is high only while the block is idle, and a command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. A held command waits without loss until the block is idle again.

On the memory side, `mem_req` acts as valid and `mem_ack` acts as ready. Address, write flag and write data stay frozen until acknowledged, so memory may stall any beat for as long as it needs. Words read from memory are gathered in an internal image buffer. They reach the register file only through commit strobes that fire once the whole image has arrived. The stack depth parameter must be even so that the image is a whole number of words.

Top module: `cpst_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `mem_req`, `done`, `init_pulse`, `ld_env` and `ld_stk` are 0. `cmd_ready` is 1 only in idle, and a command is accepted on an edge with `cmd_valid` and `cmd_ready` both high.
- R2: Operation codes are 0 = environment store (7 writes), 1 = environment load (7 reads), 2 = full save (27 writes) and 3 = full restore (27 reads). Each operation uses the byte addresses base, base+4, base+8 and so on, in that order, with no address skipped or repeated.
- R3: Environment word i (i = 0..6) is laid out as follows. Words 0, 1, 2 and 6 hold control, status, tag and operand selector in bits 15:0, with bits 31:16 zero. Word 3 is the 32-bit instruction pointer and word 5 is the 32-bit operand address. Word 4 is {5'b0, opcode[10:0], code selector[15:0]}.
- R4: Image bytes 28..107 hold stack register ST(k) in bytes 28+10k .. 37+10k, least significant byte first. Image byte n sits in word n/4 at bits 8*(n%4)+7 .. 8*(n%4). The `cur_stk` and `new_stk` ports carry ST(k) in bits 80k+79 .. 80k.
- R5: While `mem_req` is high and `mem_ack` is low, address, write flag and write data hold steady. After an acknowledge that is not the last, the next beat's address (previous + 4) is presented in the following cycle.
- R6: In the wait form (`cmd_wait` = 1), `mem_req` stays low as long as `busy` is sampled high. The first request appears the cycle after the first edge at which `busy` is sampled low, counting from the acceptance edge. In the no-wait form, the first request appears the cycle after acceptance whatever `busy` is.
- R7: Store and save write the state values present on the `cur_*` inputs at the edge where the transfer starts. Changes to those inputs during the transfer do not alter the written words.
- R8: `done` is high for exactly one cycle, the cycle after the edge that samples the last acknowledge, for every operation.
- R9: `init_pulse` is high together with `done` after a full save, and never for any other operation.
- R10: After an environment load, `ld_env` pulses with `done`, and the `new_*` environment outputs carry the decoded fields. The upper halves of words 0, 1, 2 and 6 are ignored, and `ld_stk` stays low.
- R11: After a full restore, `ld_env` and `ld_stk` pulse together with `done`. `new_stk` carries the eight registers decoded per R4.
- R12: If reset is asserted during a load, no commit strobe and no `done` is produced, and the block returns to idle with no pending transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command taken when valid |
| cmd_op | input | 2 | Operation code (R2) |
| cmd_wait | input | 1 | 1 = wait form, hold off while busy |
| cmd_base | input | ADDR_W | Byte base address of the image |
| busy | input | 1 | Coprocessor busy flag |
| cur_ctl | input | 16 | Current control word |
| cur_sts | input | 16 | Current status word |
| cur_tag | input | 16 | Current tag word |
| cur_ip | input | 32 | Last instruction pointer |
| cur_csel | input | 16 | Last code selector |
| cur_opc | input | 11 | Last opcode |
| cur_opa | input | 32 | Last operand address |
| cur_dsel | input | 16 | Last operand selector |
| cur_stk | input | 80*NREG | Stack registers, ST(0) in the low bits |
| mem_req | output | 1 | Memory beat request (valid) |
| mem_we | output | 1 | 1 = write beat |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Beat accepted (ready) |
| mem_rdata | input | 32 | Read data, valid with mem_ack on reads |
| done | output | 1 | One-cycle completion pulse |
| init_pulse | output | 1 | Reinitialize the unit after a full save |
| ld_env | output | 1 | Commit strobe for the environment fields |
| ld_stk | output | 1 | Commit strobe for the stack registers |
| new_ctl | output | 16 | Restored control word |
| new_sts | output | 16 | Restored status word |
| new_tag | output | 16 | Restored tag word |
| new_ip | output | 32 | Restored instruction pointer |
| new_csel | output | 16 | Restored code selector |
| new_opc | output | 11 | Restored opcode |
| new_opa | output | 32 | Restored operand address |
| new_dsel | output | 16 | Restored operand selector |
| new_stk | output | 80*NREG | Restored stack registers |

## Verification
Two events can land on the same clock edge. The first is a wait-form command being accepted, which can coincide with the busy flag falling; in that case the transfer must start at once. The second is a beat stalling without acknowledge, which can coincide with the busy flag changing, and the beat must then stay frozen. The bench holds commands valid while `busy` toggles at random and memory acknowledges at random, so both coincidences happen many times. Each run is judged by the exact address sequence, the beat count, the written or committed data and a single `done` per command. Directed cases add a long busy hold, a long acknowledge stall, input changes during a save, and a reset in the middle of a restore.

// File: rtl/cpst_pkg.sv
package cpst_pkg;

  localparam int WORD_W    = 32;
  localparam int ENV_WORDS = 7;
  localparam int REG_W     = 80;

  typedef enum logic [1:0] {
    OP_ENV_STORE    = 2'd0,
    OP_ENV_LOAD     = 2'd1,
    OP_FULL_SAVE    = 2'd2,
    OP_FULL_RESTORE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_XFER = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/cpst_pack.sv
// Builds the flat image from the live state; word 0 in the low bits.
module cpst_pack
  import cpst_pkg::*;
#(
  parameter int NREG = 8,
  localparam int IMG_BITS = ENV_WORDS * WORD_W + NREG * REG_W
) (
  input  logic [15:0]            cur_ctl,
  input  logic [15:0]            cur_sts,
  input  logic [15:0]            cur_tag,
  input  logic [31:0]            cur_ip,
  input  logic [15:0]            cur_csel,
  input  logic [10:0]            cur_opc,
  input  logic [31:0]            cur_opa,
  input  logic [15:0]            cur_dsel,
  input  logic [NREG*REG_W-1:0]  cur_stk,
  output logic [IMG_BITS-1:0]    live_img
);

  // Stack bytes follow the environment back to back, little-endian,
  // so ST(0) starts right at bit ENV_WORDS*32.
  assign live_img = {cur_stk,
                     16'h0000, cur_dsel,
                     cur_opa,
                     5'b00000, cur_opc, cur_csel,
                     cur_ip,
                     16'h0000, cur_tag,
                     16'h0000, cur_sts,
                     16'h0000, cur_ctl};

endmodule

// File: rtl/cpst_unpack.sv
// Splits the gathered image into register-file fields.
module cpst_unpack
  import cpst_pkg::*;
#(
  parameter int NREG = 8,
  localparam int ENV_BITS = ENV_WORDS * WORD_W,
  localparam int IMG_BITS = ENV_BITS + NREG * REG_W
) (
  input  logic [IMG_BITS-1:0]    img,
  output logic [15:0]            new_ctl,
  output logic [15:0]            new_sts,
  output logic [15:0]            new_tag,
  output logic [31:0]            new_ip,
  output logic [15:0]            new_csel,
  output logic [10:0]            new_opc,
  output logic [31:0]            new_opa,
  output logic [15:0]            new_dsel,
  output logic [NREG*REG_W-1:0]  new_stk
);

  logic unused_hi;

  assign new_ctl  = img[0*WORD_W +: 16];
  assign new_sts  = img[1*WORD_W +: 16];
  assign new_tag  = img[2*WORD_W +: 16];
  assign new_ip   = img[3*WORD_W +: 32];
  assign new_csel = img[4*WORD_W +: 16];
  assign new_opc  = img[4*WORD_W + 16 +: 11];
  assign new_opa  = img[5*WORD_W +: 32];
  assign new_dsel = img[6*WORD_W +: 16];
  assign new_stk  = img[ENV_BITS +: NREG*REG_W];

  // Padding halves of the selector and short words carry no state.
  assign unused_hi = ^{img[0*WORD_W+16 +: 16], img[1*WORD_W+16 +: 16],
                       img[2*WORD_W+16 +: 16], img[4*WORD_W+27 +: 5],
                       img[6*WORD_W+16 +: 16]};

endmodule

// File: rtl/cpst_image.sv
// Word-organized image buffer: snapshot for writes, gather for reads.
module cpst_image
  import cpst_pkg::*;
#(
  parameter int WORDS = 27,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic                     clk,
  input  logic                     snap,
  input  logic [WORDS*WORD_W-1:0]  live_img,
  input  logic                     rd_beat,
  input  logic [IDX_W-1:0]         word_idx,
  input  logic [WORD_W-1:0]        rdata,
  output logic [WORDS*WORD_W-1:0]  img,
  output logic [WORD_W-1:0]        wdata
);

  logic [WORD_W-1:0] word_q [WORDS];

  always_ff @(posedge clk) begin
    for (int w = 0; w < WORDS; w++) begin
      if (snap)
        word_q[w] <= live_img[w*WORD_W +: WORD_W];
      else if (rd_beat && (word_idx == IDX_W'(w)))
        word_q[w] <= rdata;
    end
  end

  generate
    for (genvar g = 0; g < WORDS; g++) begin : g_flat
      assign img[g*WORD_W +: WORD_W] = word_q[g];
    end
  endgenerate

  always_comb begin
    wdata = '0;
    for (int w = 0; w < WORDS; w++)
      if (word_idx == IDX_W'(w)) wdata = word_q[w];
  end

endmodule

// File: rtl/cpst_ctrl.sv
// Command acceptance, busy gating, beat sequencing and completion.
module cpst_ctrl
  import cpst_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int FULL_WORDS = 27,
  localparam int IDX_W     = $clog2(FULL_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_wait,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  output logic [IDX_W-1:0]  word_idx,
  output logic              snap,
  output logic              rd_beat,
  output logic              done,
  output logic              init_pulse,
  output logic              ld_env,
  output logic              ld_stk
);

  seq_state_e        state_q;
  op_e               op_q;
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;
  logic              accept, go_now, last_w;
  logic [IDX_W-1:0]  final_idx;

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign go_now    = accept && (!cmd_wait || !busy);
  assign final_idx = op_q[1] ? IDX_W'(FULL_WORDS - 1) : IDX_W'(ENV_WORDS - 1);
  assign last_w    = (idx_q == final_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_ENV_STORE;
      base_q  <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          op_q    <= op_e'(cmd_op);
          base_q  <= cmd_base;
          idx_q   <= '0;
          state_q <= go_now ? ST_XFER : ST_HOLD;
        end
        ST_HOLD: if (!busy) state_q <= ST_XFER;
        ST_XFER: if (mem_ack) begin
          if (last_w) state_q <= ST_FIN;
          else        idx_q   <= idx_q + 1'b1;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req  = (state_q == ST_XFER);
  assign mem_we   = mem_req && !op_q[0];
  assign mem_addr = base_q + ADDR_W'({idx_q, 2'b00});
  assign word_idx = idx_q;
  assign rd_beat  = mem_req && mem_ack && op_q[0];

  // Writes sample the live state on the edge where the transfer starts.
  assign snap = (go_now && !cmd_op[0]) ||
                ((state_q == ST_HOLD) && !busy && !op_q[0]);

  assign done       = (state_q == ST_FIN);
  assign init_pulse = done && (op_q == OP_FULL_SAVE);
  assign ld_env     = done && op_q[0];
  assign ld_stk     = done && (op_q == OP_FULL_RESTORE);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !last_w |=> mem_req && (mem_addr == $past(mem_addr) + ADDR_W'(4))); // R5
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) && busy |=> !mem_req); // R6
  AST_NOWAIT_START: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !cmd_wait |=> mem_req); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req && mem_ack)); // R8

endmodule

// File: rtl/cpst_seq.sv
module cpst_seq
  import cpst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREG   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [1:0]             cmd_op,
  input  logic                   cmd_wait,
  input  logic [ADDR_W-1:0]      cmd_base,
  input  logic                   busy,
  input  logic [15:0]            cur_ctl,
  input  logic [15:0]            cur_sts,
  input  logic [15:0]            cur_tag,
  input  logic [31:0]            cur_ip,
  input  logic [15:0]            cur_csel,
  input  logic [10:0]            cur_opc,
  input  logic [31:0]            cur_opa,
  input  logic [15:0]            cur_dsel,
  input  logic [NREG*80-1:0]     cur_stk,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [31:0]            mem_wdata,
  input  logic                   mem_ack,
  input  logic [31:0]            mem_rdata,
  output logic                   done,
  output logic                   init_pulse,
  output logic                   ld_env,
  output logic                   ld_stk,
  output logic [15:0]            new_ctl,
  output logic [15:0]            new_sts,
  output logic [15:0]            new_tag,
  output logic [31:0]            new_ip,
  output logic [15:0]            new_csel,
  output logic [10:0]            new_opc,
  output logic [31:0]            new_opa,
  output logic [15:0]            new_dsel,
  output logic [NREG*80-1:0]     new_stk
);

  localparam int IMG_BITS   = ENV_WORDS * WORD_W + NREG * REG_W;
  localparam int FULL_WORDS = IMG_BITS / WORD_W;
  localparam int IDX_W      = $clog2(FULL_WORDS);

  logic [IMG_BITS-1:0] live_img, img;
  logic [IDX_W-1:0]    word_idx;
  logic                snap, rd_beat;

  cpst_ctrl #(.ADDR_W(ADDR_W), .FULL_WORDS(FULL_WORDS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_wait   (cmd_wait),
    .cmd_base   (cmd_base),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .word_idx   (word_idx),
    .snap       (snap),
    .rd_beat    (rd_beat),
    .done       (done),
    .init_pulse (init_pulse),
    .ld_env     (ld_env),
    .ld_stk     (ld_stk)
  );

  cpst_pack #(.NREG(NREG)) u_pack (
    .cur_ctl  (cur_ctl),
    .cur_sts  (cur_sts),
    .cur_tag  (cur_tag),
    .cur_ip   (cur_ip),
    .cur_csel (cur_csel),
    .cur_opc  (cur_opc),
    .cur_opa  (cur_opa),
    .cur_dsel (cur_dsel),
    .cur_stk  (cur_stk),
    .live_img (live_img)
  );

  cpst_image #(.WORDS(FULL_WORDS)) u_image (
    .clk      (clk),
    .snap     (snap),
    .live_img (live_img),
    .rd_beat  (rd_beat),
    .word_idx (word_idx),
    .rdata    (mem_rdata),
    .img      (img),
    .wdata    (mem_wdata)
  );

  cpst_unpack #(.NREG(NREG)) u_unpack (
    .img      (img),
    .new_ctl  (new_ctl),
    .new_sts  (new_sts),
    .new_tag  (new_tag),
    .new_ip   (new_ip),
    .new_csel (new_csel),
    .new_opc  (new_opc),
    .new_opa  (new_opa),
    .new_dsel (new_dsel),
    .new_stk  (new_stk)
  );

  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !mem_ack |=> $stable(mem_wdata)); // R5
  AST_INIT_ONLY_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |-> done && !ld_env && !mem_req); // R9
  AST_STK_WITH_ENV: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stk |-> ld_env && done); // R11
  AST_CMD_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !done && !mem_req); // R1

endmodule

// File: tb/cpst_seq_tb.sv
`timescale 1ns/1ps
module cpst_seq_tb;

  localparam int NREG = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cmd_valid, cmd_ready, cmd_wait, busy;
  logic [1:0] cmd_op;
  logic [31:0] cmd_base;
  logic [15:0] cur_ctl, cur_sts, cur_tag, cur_csel, cur_dsel;
  logic [31:0] cur_ip, cur_opa;
  logic [10:0] cur_opc;
  logic [NREG*80-1:0] cur_stk;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic done, init_pulse, ld_env, ld_stk;
  logic [15:0] new_ctl, new_sts, new_tag, new_csel, new_dsel;
  logic [31:0] new_ip, new_opa;
  logic [10:0] new_opc;
  logic [NREG*80-1:0] new_stk;

  cpst_seq #(.ADDR_W(32), .NREG(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wait(cmd_wait), .cmd_base(cmd_base), .busy(busy),
    .cur_ctl(cur_ctl), .cur_sts(cur_sts), .cur_tag(cur_tag), .cur_ip(cur_ip),
    .cur_csel(cur_csel), .cur_opc(cur_opc), .cur_opa(cur_opa), .cur_dsel(cur_dsel),
    .cur_stk(cur_stk), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .init_pulse(init_pulse), .ld_env(ld_env), .ld_stk(ld_stk),
    .new_ctl(new_ctl), .new_sts(new_sts), .new_tag(new_tag), .new_ip(new_ip),
    .new_csel(new_csel), .new_opc(new_opc), .new_opa(new_opa), .new_dsel(new_dsel),
    .new_stk(new_stk)
  );

  // Bench state
  logic [31:0] mem [0:255];
  int n_chk = 0, n_fail = 0;
  int beats, done_cnt, init_cnt, env_cnt, stk_cnt;
  logic [31:0] exp_addr;
  bit addr_err, stall_ack, rand_busy, finished;
  logic [15:0] e_ctl, e_sts, e_tag, e_csel, e_dsel;
  logic [31:0] e_ip, e_opa;
  logic [10:0] e_opc;
  logic [NREG*80-1:0] e_stk;
  logic [15:0] c_ctl, c_sts, c_tag, c_csel, c_dsel;
  logic [31:0] c_ip, c_opa;
  logic [10:0] c_opc;
  logic [NREG*80-1:0] c_stk;

  task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Memory responder and observer, all at the falling edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
    end else begin
      mem_ack   = mem_req && !stall_ack && ($urandom_range(0, 3) != 0);
      mem_rdata = mem[mem_addr[9:2]];
      if (mem_req && mem_ack) begin
        if (mem_addr !== exp_addr) addr_err = 1'b1;
        exp_addr = exp_addr + 32'd4;
        beats++;
        if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
      end
      if (rand_busy) busy = ($urandom_range(0, 2) == 0);
      if (done) done_cnt++;
      if (init_pulse) init_cnt++;
      if (ld_env) begin
        env_cnt++;
        c_ctl = new_ctl; c_sts = new_sts; c_tag = new_tag; c_ip = new_ip;
        c_csel = new_csel; c_opc = new_opc; c_opa = new_opa; c_dsel = new_dsel;
      end
      if (ld_stk) begin
        stk_cnt++;
        c_stk = new_stk;
      end
    end
  end

  // Expected image word from the snapshot values (R3, R4).
  function automatic logic [31:0] exp_word(input int i);
    logic [31:0] w;
    w = '0;
    case (i)
      0: w = {16'h0, e_ctl};
      1: w = {16'h0, e_sts};
      2: w = {16'h0, e_tag};
      3: w = e_ip;
      4: w = {5'h0, e_opc, e_csel};
      5: w = e_opa;
      6: w = {16'h0, e_dsel};
      default: for (int j = 0; j < 4; j++) begin
        int n;
        n = 4*i + j - 28;
        w[8*j +: 8] = e_stk[(n/10)*80 + (n%10)*8 +: 8];
      end
    endcase
    return w;
  endfunction

  // Expected stack register k decoded from memory image at word bw (R4).
  function automatic logic [79:0] exp_reg(input int bw, input int k);
    logic [79:0] r;
    for (int b = 0; b < 10; b++) begin
      int n;
      logic [31:0] wd;
      n = 28 + 10*k + b;
      wd = mem[bw + n/4];
      r[8*b +: 8] = wd[8*(n%4) +: 8];
    end
    return r;
  endfunction

  task automatic new_state();
    e_ctl = 16'($urandom); e_sts = 16'($urandom); e_tag = 16'($urandom);
    e_ip = $urandom; e_csel = 16'($urandom); e_opc = 11'($urandom);
    e_opa = $urandom; e_dsel = 16'($urandom);
    for (int q = 0; q < NREG*80/32; q++) e_stk[q*32 +: 32] = $urandom;
    cur_ctl = e_ctl; cur_sts = e_sts; cur_tag = e_tag; cur_ip = e_ip;
    cur_csel = e_csel; cur_opc = e_opc; cur_opa = e_opa; cur_dsel = e_dsel;
    cur_stk = e_stk;
  endtask

  task automatic clear_counts(input logic [31:0] base);
    beats = 0; done_cnt = 0; init_cnt = 0; env_cnt = 0; stk_cnt = 0;
    addr_err = 1'b0; exp_addr = base;
  endtask

  task automatic send(input logic [1:0] op, input bit w, input logic [31:0] base);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wait = w; cmd_base = base;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (done_cnt == 0 && t < 4000) begin @(negedge clk); t++; end
    if (done_cnt == 0) check("R8 timeout waiting for done", 0, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic verify(input logic [1:0] op, input logic [31:0] base);
    int nw, bw;
    nw = op[1] ? 27 : 7;
    bw = int'(base >> 2);
    check("R2 beat count", 80'(beats), 80'(nw));
    check("R2 R5 address sequence error", 80'(addr_err), 0);
    check("R8 done pulses", 80'(done_cnt), 1);
    check("R9 init pulses", 80'(init_cnt), 80'(op == 2'd2));
    check("R10 R11 env commit pulses", 80'(env_cnt), 80'(op[0]));
    check("R10 R11 stack commit pulses", 80'(stk_cnt), 80'(op == 2'd3));
    if (!op[0]) begin
      for (int i = 0; i < nw; i++)
        check(i < 7 ? "R3 R7 stored env word" : "R4 R7 stored stack word",
              80'(mem[bw + i]), 80'(exp_word(i)));
    end else begin
      check("R10 ctl", 80'(c_ctl), 80'(mem[bw][15:0]));
      check("R10 sts", 80'(c_sts), 80'(mem[bw+1][15:0]));
      check("R10 tag", 80'(c_tag), 80'(mem[bw+2][15:0]));
      check("R10 ip", 80'(c_ip), 80'(mem[bw+3]));
      check("R10 csel", 80'(c_csel), 80'(mem[bw+4][15:0]));
      check("R10 opc", 80'(c_opc), 80'(mem[bw+4][26:16]));
      check("R10 opa", 80'(c_opa), 80'(mem[bw+5]));
      check("R10 dsel", 80'(c_dsel), 80'(mem[bw+6][15:0]));
      if (op == 2'd3)
        for (int k = 0; k < NREG; k++)
          check("R11 restored stack reg", c_stk[k*80 +: 80], exp_reg(bw, k));
    end
  endtask

  task automatic run_op(input logic [1:0] op, input bit w, input logic [31:0] base);
    clear_counts(base);
    send(op, w, base);
    wait_done();
    verify(op, base);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] a0;
    void'($urandom(32'h1f2e3d4c));
    finished = 1'b0; stall_ack = 1'b0; rand_busy = 1'b0; busy = 1'b0;
    cmd_valid = 1'b0; cmd_op = 2'd0; cmd_wait = 1'b0; cmd_base = '0;
    mem_ack = 1'b0; mem_rdata = '0;
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    new_state();
    clear_counts(0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 cmd_ready after reset", 80'(cmd_ready), 1);
    check("R1 mem_req after reset", 80'(mem_req), 0);
    check("R1 strobes after reset", 80'({done, init_pulse, ld_env, ld_stk}), 0);

    // Directed: each operation, no-wait, busy low
    run_op(2'd0, 1'b0, 32'h40);
    run_op(2'd2, 1'b0, 32'h100);
    run_op(2'd3, 1'b0, 32'h100);
    // R10 upper halves ignored: set junk in upper halves
    mem[8'h20][31:16] = 16'hdead; mem[8'h22][31:16] = 16'hbeef;
    run_op(2'd1, 1'b0, 32'h80);

    // R6 wait form holds while busy
    new_state();
    clear_counts(32'h200);
    busy = 1'b1;
    send(2'd2, 1'b1, 32'h200);
    for (int i = 0; i < 6; i++) begin
      check("R6 no request while busy", 80'(mem_req), 0);
      @(negedge clk);
    end
    busy = 1'b0;
    @(negedge clk);
    check("R6 request after busy drops", 80'(mem_req), 1);
    wait_done();
    verify(2'd2, 32'h200);

    // R6 no-wait form ignores busy
    clear_counts(32'h200);
    busy = 1'b1;
    send(2'd3, 1'b0, 32'h200);
    check("R6 no-wait starts while busy", 80'(mem_req), 1);
    wait_done();
    busy = 1'b0;
    verify(2'd3, 32'h200);

    // R7 snapshot plus R5 stall
    new_state();
    clear_counts(32'h300);
    send(2'd2, 1'b0, 32'h300);
    while (beats < 2) @(negedge clk);
    cur_ctl = ~e_ctl; cur_ip = ~e_ip; cur_stk = ~e_stk;
    stall_ack = 1'b1;
    @(negedge clk);
    a0 = mem_addr;
    repeat (6) @(negedge clk);
    check("R5 request held during stall", 80'(mem_req), 1);
    check("R5 address held during stall", 80'(mem_addr), 80'(a0));
    stall_ack = 1'b0;
    wait_done();
    verify(2'd2, 32'h300);

    // R12 reset during restore
    clear_counts(32'h100);
    send(2'd3, 1'b0, 32'h100);
    while (beats < 3) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 no env commit after abort", 80'(env_cnt), 0);
    check("R12 no stack commit after abort", 80'(stk_cnt), 0);
    check("R12 no done after abort", 80'(done_cnt), 0);
    check("R12 idle after abort", 80'({cmd_ready, mem_req}), 80'(2'b10));

    // Random mix with toggling busy
    rand_busy = 1'b1;
    for (int r = 0; r < 24; r++) begin
      logic [1:0] op;
      logic [31:0] base;
      op = 2'($urandom);
      base = 32'($urandom_range(0, 200)) << 2;
      if (!op[0]) new_state();
      run_op(op, 1'($urandom), base);
    end
    rand_busy = 1'b0;
    busy = 1'b0;

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule